// File: doc/BRIEF.md
# Planar Graphics Memory Write Datapath

This block connects a byte-wide processor bus to four 8-bit memory planes that share one address. Every processor read of the array fetches one byte from each plane at once and parks the four bytes in a hidden 32-bit latch. Every processor write builds four new plane bytes. It combines the processor byte (rotated and passed through a logic function), the latch, a per-plane fill colour and a bit mask. Software can therefore fill, recolour and copy pixels in all four planes with single byte accesses.

Configuration goes through an index/data register pair. The processor first writes an index to the address port and then reads or writes the data port. The register file holds the fill colour and its per-plane enable, the rotate count with the logic function, the read plane select, the read/write mode, the bit mask and a per-plane write enable. The plane storage is a behavioural synchronous RAM with a registered read. A write issued in the cycle right after a read still combines with the bytes that read fetched.

Top module: `pgw_top`

## Requirements
- R1: Each memory read (`mem_rd`) loads all four plane bytes at `mem_addr` into the latch. No other operation changes the latch, including memory writes and register accesses.
- R2: In read mode 0 (mode register bit 3 clear), `mem_rdata` returns the byte of the plane named by read plane select bits 1:0. It updates on the second rising edge after the request is driven, and holds otherwise. A read and a write are never requested in the same cycle.
- R3: `cfg_sel`=0 selects the address port: a write stores the index and a read returns it. `cfg_sel`=1 selects the data port at the current index. Index 0 is the fill colour, 1 the colour enable, 2 rotate/function, 3 read plane select, 4 mode, 5 bit mask and 6 plane write enable. All of these are 8 bits wide and read back in full. Any other index reads 0. `cfg_rdata` updates on the edge that samples `cfg_rd`.
- R4: In write modes 0 and 1 of the function path, rotate/function bits 2:0 rotate the processor byte right by that count. Bits 4:3 then select the function against the plane's latch byte: 0 passes the value, 1 ANDs, 2 ORs and 3 XORs.
- R5: In write modes 0 and 2, each bit where the bit mask is 0 takes the latch bit, and each bit where it is 1 takes the function result.
- R6: In write mode 0, a plane whose colour enable bit (bit p for plane p) is set uses its fill colour bit p repeated across the byte instead of the rotated byte. A read followed by a write of any data therefore paints the colour under the mask.
- R7: Write mode 1 (mode bits 1:0 = 1) writes each plane's latch byte unchanged, whatever the data, function and mask.
- R8: Write mode 2 repeats processor data bit p across plane p's byte, then applies the function and the bit mask.
- R9: Write mode 3 uses fill colour bit p repeated as the data for plane p. It applies the function and uses the rotated processor byte ANDed with the bit mask as the mask.
- R10: Only planes whose plane write enable bit is set are updated by a memory write. The other planes keep their contents.
- R11: In read mode 1 (mode bit 3 set), bit i of `mem_rdata` is 1 when, for every plane p, bit i of plane p equals fill colour bit p.
- R12: After reset the bit mask is 0xFF, the plane write enable is 0x0F, all other registers and the index are 0, and `cfg_rdata` and `mem_rdata` are 0.
- R13: A write in the cycle right after a read uses the bytes fetched by that read as its latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_rd | input | 1 | Register port read strobe |
| cfg_sel | input | 1 | 0 = address port, 1 = data port |
| cfg_wdata | input | 8 | Register port write data |
| cfg_rdata | output | 8 | Register port read data |
| mem_wr | input | 1 | Memory write strobe |
| mem_rd | input | 1 | Memory read strobe |
| mem_addr | input | 8 | Byte address shared by all planes |
| mem_wdata | input | 8 | Processor write byte |
| mem_rdata | output | 8 | Processor read byte |

## Verification
The assertions assume that a memory read and a memory write are never requested together, so the latch and the mask checks see only one access per cycle. The stimulus also never changes the mode or the read plane select between a read and its result. It reads only addresses it has written before. Each memory access is framed by idle or register cycles, except in the one back-to-back read-then-write case that exercises latch forwarding.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int IX_SR   = 0;
  localparam int IX_ESR  = 1;
  localparam int IX_ROT  = 2;
  localparam int IX_RPS  = 3;
  localparam int IX_MODE = 4;
  localparam int IX_MASK = 5;
  localparam int IX_PWE  = 6;

  typedef enum logic [1:0] {FN_PASS = 2'd0, FN_AND = 2'd1, FN_OR = 2'd2, FN_XOR = 2'd3} fn_e;
  typedef enum logic [1:0] {WM_MERGE = 2'd0, WM_LATCH = 2'd1, WM_COLOR = 2'd2, WM_STAMP = 2'd3} wmode_e;
endpackage

// File: rtl/pgw_regs.sv
module pgw_regs import pgw_pkg::*; #(
  parameter int DW  = 8,
  parameter int NPL = 4,
  localparam int RCW = $clog2(DW),
  localparam int PSW = $clog2(NPL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic           cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  output logic [NPL-1:0] srv,
  output logic [NPL-1:0] esr,
  output logic [NPL-1:0] pwe,
  output logic [RCW-1:0] rot_cnt,
  output fn_e            fn,
  output logic [PSW-1:0] rd_plane,
  output wmode_e         wmode,
  output logic           rmode,
  output logic [DW-1:0]  bmask
);
  logic [DW-1:0] idx_q, sr_q, esr_q, rot_q, rps_q, mode_q, mask_q, pwe_q;
  logic [DW-1:0] rd_mux;

  always_comb begin
    case (int'(idx_q))
      IX_SR:   rd_mux = sr_q;
      IX_ESR:  rd_mux = esr_q;
      IX_ROT:  rd_mux = rot_q;
      IX_RPS:  rd_mux = rps_q;
      IX_MODE: rd_mux = mode_q;
      IX_MASK: rd_mux = mask_q;
      IX_PWE:  rd_mux = pwe_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      sr_q      <= '0;
      esr_q     <= '0;
      rot_q     <= '0;
      rps_q     <= '0;
      mode_q    <= '0;
      mask_q    <= '1;
      pwe_q     <= DW'({NPL{1'b1}});
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr && !cfg_sel) idx_q <= cfg_wdata;
      if (cfg_wr && cfg_sel) begin
        case (int'(idx_q))
          IX_SR:   sr_q   <= cfg_wdata;
          IX_ESR:  esr_q  <= cfg_wdata;
          IX_ROT:  rot_q  <= cfg_wdata;
          IX_RPS:  rps_q  <= cfg_wdata;
          IX_MODE: mode_q <= cfg_wdata;
          IX_MASK: mask_q <= cfg_wdata;
          IX_PWE:  pwe_q  <= cfg_wdata;
          default: ;
        endcase
      end
      if (cfg_rd) cfg_rdata <= cfg_sel ? rd_mux : idx_q;
    end
  end

  assign srv      = sr_q[NPL-1:0];
  assign esr      = esr_q[NPL-1:0];
  assign pwe      = pwe_q[NPL-1:0];
  assign rot_cnt  = rot_q[RCW-1:0];
  assign fn       = fn_e'(rot_q[RCW+1:RCW]);
  assign rd_plane = rps_q[PSW-1:0];
  assign wmode    = wmode_e'(mode_q[1:0]);
  assign rmode    = mode_q[3];
  assign bmask    = mask_q;

  AST_IDX_READBACK: assert property (@(posedge clk) disable iff (rst) (cfg_rd && !cfg_sel) |=> (cfg_rdata == $past(idx_q))); // R3
endmodule

// File: rtl/pgw_lane.sv
module pgw_lane import pgw_pkg::*; #(
  parameter int DW = 8
) (
  input  wmode_e        wmode,
  input  fn_e           fn,
  input  logic [DW-1:0] rot_byte,
  input  logic          cpu_bit,
  input  logic          sr_bit,
  input  logic          esr_bit,
  input  logic [DW-1:0] bmask,
  input  logic [DW-1:0] lat,
  output logic [DW-1:0] wdat
);
  logic [DW-1:0] src, msk, alu;

  always_comb begin
    case (wmode)
      WM_MERGE: begin src = esr_bit ? {DW{sr_bit}} : rot_byte; msk = bmask; end
      WM_COLOR: begin src = {DW{cpu_bit}};                     msk = bmask; end
      WM_STAMP: begin src = {DW{sr_bit}};                      msk = bmask & rot_byte; end
      default:  begin src = lat;                               msk = '0; end
    endcase
    case (fn)
      FN_AND:  alu = src & lat;
      FN_OR:   alu = src | lat;
      FN_XOR:  alu = src ^ lat;
      default: alu = src;
    endcase
    wdat = (alu & msk) | (lat & ~msk);
  end
endmodule

// File: rtl/pgw_planes.sv
module pgw_planes #(
  parameter int DW  = 8,
  parameter int NPL = 4,
  parameter int AW  = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic [NPL-1:0]    we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [NPL*DW-1:0] wdata,
  output logic [NPL*DW-1:0] q
);
  for (genvar p = 0; p < NPL; p++) begin : g_plane
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q_p;
    always_ff @(posedge clk) begin
      if (we[p]) mem[addr] <= wdata[p*DW +: DW];
      if (re) q_p <= mem[addr];
    end
    assign q[p*DW +: DW] = q_p;
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top import pgw_pkg::*; #(
  parameter int DW  = 8,
  parameter int NPL = 4,
  parameter int AW  = 8,
  localparam int RCW = $clog2(DW),
  localparam int PSW = $clog2(NPL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          mem_wr,
  input  logic          mem_rd,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_rdata
);
  logic [NPL-1:0]    srv, esr, pwe;
  logic [RCW-1:0]    rot_cnt;
  fn_e               fn;
  logic [PSW-1:0]    rd_plane;
  wmode_e            wmode;
  logic              rmode;
  logic [DW-1:0]     bmask;
  logic [DW-1:0]     rot_byte, cmp;
  logic              rd_pend;
  logic [NPL*DW-1:0] latch_q, plane_q, lat_eff, plane_wdat;
  logic [NPL-1:0]    plane_we;

  pgw_regs #(.DW(DW), .NPL(NPL)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .srv(srv), .esr(esr), .pwe(pwe),
    .rot_cnt(rot_cnt), .fn(fn), .rd_plane(rd_plane), .wmode(wmode), .rmode(rmode),
    .bmask(bmask)
  );

  always_comb begin
    for (int i = 0; i < DW; i++) rot_byte[i] = mem_wdata[(i + int'(rot_cnt)) % DW];
  end

  // Forward freshly read bytes so a write right after a read needs no stall
  assign lat_eff  = rd_pend ? plane_q : latch_q;
  assign plane_we = mem_wr ? pwe : '0;

  for (genvar p = 0; p < NPL; p++) begin : g_lane
    pgw_lane #(.DW(DW)) u_lane (
      .wmode(wmode), .fn(fn), .rot_byte(rot_byte), .cpu_bit(mem_wdata[p]),
      .sr_bit(srv[p]), .esr_bit(esr[p]), .bmask(bmask),
      .lat(lat_eff[p*DW +: DW]), .wdat(plane_wdat[p*DW +: DW])
    );
  end

  pgw_planes #(.DW(DW), .NPL(NPL), .AW(AW)) u_planes (
    .clk(clk), .we(plane_we), .re(mem_rd), .addr(mem_addr),
    .wdata(plane_wdat), .q(plane_q)
  );

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      cmp[i] = 1'b1;
      for (int p = 0; p < NPL; p++)
        if (plane_q[p*DW + i] != srv[p]) cmp[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      latch_q   <= '0;
      mem_rdata <= '0;
    end else begin
      rd_pend <= mem_rd;
      if (rd_pend) begin
        latch_q   <= plane_q;
        mem_rdata <= rmode ? cmp : plane_q[int'(rd_plane)*DW +: DW];
      end
    end
  end

  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_pend |=> $stable(latch_q)); // R1
  AST_COPY_MODE: assert property (@(posedge clk) disable iff (rst) (mem_wr && wmode == WM_LATCH) |-> (plane_wdat == lat_eff)); // R7
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst) (mem_wr && wmode != WM_STAMP) |-> (((plane_wdat ^ lat_eff) & ~{NPL{bmask}}) == '0)); // R5
endmodule

// File: tb/pgw_top_tb.sv
module pgw_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 0, cfg_rd = 0, cfg_sel = 0, mem_wr = 0, mem_rd = 0;
  logic [7:0] cfg_wdata = 0, mem_addr = 0, mem_wdata = 0;
  logic [7:0] cfg_rdata, mem_rdata;
  int n_chk = 0, n_err = 0;
  string cur_req = "R12";
  bit done = 0;

  always #2 clk = ~clk;

  pgw_top u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural reference model
  int m_mem [4][256];
  int m_q [4];
  int m_lat [4];
  int tmp_le [4];
  bit m_pend;
  int r_sr, r_esr, r_rot, r_rps, r_mode, r_mask, r_pwe, r_idx;
  int exp_cd, exp_md;

  function automatic int regread(int i);
    case (i)
      0: return r_sr;   1: return r_esr;  2: return r_rot;  3: return r_rps;
      4: return r_mode; 5: return r_mask; 6: return r_pwe;
      default: return 0;
    endcase
  endfunction

  function automatic int wr_plane(int p, int d, int lat);
    int wm = r_mode & 3, cnt = r_rot & 7, fn = (r_rot >> 3) & 3;
    int rot = ((d >> cnt) | (d << (8 - cnt))) & 255;
    int res = 0;
    if (wm == 1) return lat;
    for (int b = 0; b < 8; b++) begin
      int s, m, l, f;
      m = (r_mask >> b) & 1;
      l = (lat >> b) & 1;
      if (wm == 0) s = ((r_esr >> p) & 1) ? ((r_sr >> p) & 1) : ((rot >> b) & 1);
      else if (wm == 2) s = (d >> p) & 1;
      else begin s = (r_sr >> p) & 1; m = m & ((rot >> b) & 1); end
      f = (fn == 0) ? s : (fn == 1) ? (s & l) : (fn == 2) ? (s | l) : (s ^ l);
      res |= ((m != 0) ? f : l) << b;
    end
    return res;
  endfunction

  function automatic int readfn();
    int res = 0;
    if (((r_mode >> 3) & 1) == 0) return m_q[r_rps & 3];
    for (int b = 0; b < 8; b++) begin
      bit all = 1;
      for (int p = 0; p < 4; p++) if (((m_q[p] >> b) & 1) != ((r_sr >> p) & 1)) all = 0;
      res |= int'(all) << b;
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      r_sr = 0; r_esr = 0; r_rot = 0; r_rps = 0; r_mode = 0; r_mask = 255; r_pwe = 15; r_idx = 0;
      exp_cd = 0; exp_md = 0; m_pend = 0;
      for (int p = 0; p < 4; p++) m_lat[p] = 0;
    end else begin
      for (int p = 0; p < 4; p++) tmp_le[p] = m_pend ? m_q[p] : m_lat[p];
      if (m_pend) begin
        exp_md = readfn();
        for (int p = 0; p < 4; p++) m_lat[p] = m_q[p];
      end
      if (mem_wr)
        for (int p = 0; p < 4; p++)
          if ((r_pwe >> p) & 1) m_mem[p][mem_addr] = wr_plane(p, int'(mem_wdata), tmp_le[p]);
      if (mem_rd) for (int p = 0; p < 4; p++) m_q[p] = m_mem[p][mem_addr];
      m_pend = mem_rd;
      if (cfg_rd) exp_cd = cfg_sel ? regread(r_idx) : r_idx;
      if (cfg_wr) begin
        if (!cfg_sel) r_idx = int'(cfg_wdata);
        else case (r_idx)
          0: r_sr = int'(cfg_wdata);   1: r_esr = int'(cfg_wdata);
          2: r_rot = int'(cfg_wdata);  3: r_rps = int'(cfg_wdata);
          4: r_mode = int'(cfg_wdata); 5: r_mask = int'(cfg_wdata);
          6: r_pwe = int'(cfg_wdata);  default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 register port vs model", {24'd0, cfg_rdata}, exp_cd);
      check({cur_req, " memory read vs model"}, {24'd0, mem_rdata}, exp_md);
    end
  end

  task automatic cfgw(input bit sel, input int v);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = 8'(v);
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic setreg(input int i, input int v);
    cfgw(0, i); cfgw(1, v);
  endtask

  task automatic cfgr(input bit sel, output logic [7:0] v);
    @(negedge clk); cfg_rd = 1; cfg_sel = sel;
    @(negedge clk); cfg_rd = 0; v = cfg_rdata;
  endtask

  task automatic memw(input int a, input int d);
    @(negedge clk); mem_wr = 1; mem_addr = 8'(a); mem_wdata = 8'(d);
    @(negedge clk); mem_wr = 0;
  endtask

  task automatic memr(input int a, output logic [7:0] v);
    @(negedge clk); mem_rd = 1; mem_addr = 8'(a);
    @(negedge clk); mem_rd = 0;
    @(negedge clk); v = mem_rdata;
  endtask

  task automatic chk_plane(input int a, input int p, input int exp, input string req);
    logic [7:0] v;
    cur_req = req;
    setreg(3, p);
    memr(a, v);
    check(req, {24'd0, v}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R12 reset state
    check("R12 cfg_rdata reset", {24'd0, cfg_rdata}, 0);
    check("R12 mem_rdata reset", {24'd0, mem_rdata}, 0);
    cfgw(0, 5); cfgr(1, v); check("R12 bit mask reset", {24'd0, v}, 8'hFF);
    cfgw(0, 6); cfgr(1, v); check("R12 plane enable reset", {24'd0, v}, 8'h0F);
    cfgw(0, 2); cfgr(1, v); check("R12 rotate reset", {24'd0, v}, 0);
    // R3 index/data ports
    cur_req = "R3";
    cfgw(0, 4); cfgr(0, v); check("R3 index readback", {24'd0, v}, 4);
    setreg(2, 8'h1B); cfgr(1, v); check("R3 data readback", {24'd0, v}, 8'h1B);
    setreg(3, 8'hFF); cfgr(1, v); check("R3 full width readback", {24'd0, v}, 8'hFF);
    cfgw(0, 9); cfgr(1, v); check("R3 unused index", {24'd0, v}, 0);
    setreg(2, 0); setreg(3, 0);
    // Fill planes, R10 plane enables
    cur_req = "R10";
    memw(0, 8'hA5);
    setreg(6, 1); memw(1, 8'h11);
    setreg(6, 2); memw(1, 8'h22);
    setreg(6, 4); memw(1, 8'h44);
    setreg(6, 8); memw(1, 8'h88);
    setreg(6, 15);
    chk_plane(1, 2, 8'h44, "R10");
    chk_plane(1, 0, 8'h11, "R2");
    chk_plane(0, 3, 8'hA5, "R2");
    // R13 read then write next cycle, in copy mode R7
    cur_req = "R13";
    setreg(4, 1);
    @(negedge clk); mem_rd = 1; mem_addr = 1;
    @(negedge clk); mem_rd = 0; mem_wr = 1; mem_addr = 2; mem_wdata = 0;
    @(negedge clk); mem_wr = 0;
    setreg(4, 0);
    chk_plane(2, 3, 8'h88, "R13");
    chk_plane(2, 1, 8'h22, "R7");
    // R1 latch held across a write and register traffic
    cur_req = "R1";
    memr(1, v);
    memw(10, 0);
    setreg(4, 1); memw(9, 8'h5A); setreg(4, 0);
    chk_plane(9, 2, 8'h44, "R1");
    chk_plane(10, 1, 8'h00, "R1");
    // R4 rotate and functions
    setreg(2, 8'h0C); memr(0, v); memw(3, 8'h3C); chk_plane(3, 0, 8'h81, "R4");
    setreg(2, 8'h19); memr(0, v); memw(3, 8'h03); chk_plane(3, 2, 8'h24, "R4");
    setreg(2, 8'h10); memr(0, v); memw(3, 8'h0F); chk_plane(3, 1, 8'hAF, "R4");
    setreg(2, 0);
    // R5 bit mask
    setreg(5, 8'h0F); memr(0, v); memw(4, 0); setreg(5, 8'hFF);
    chk_plane(4, 3, 8'hA0, "R5");
    // R6 set/reset colour
    setreg(0, 5); setreg(1, 15); setreg(5, 8'h3C); memr(0, v); memw(5, 0); setreg(5, 8'hFF);
    chk_plane(5, 0, 8'hBD, "R6");
    chk_plane(5, 1, 8'h81, "R6");
    setreg(0, 0); setreg(1, 1); memr(0, v); memw(6, 8'h77);
    chk_plane(6, 0, 8'h00, "R6");
    chk_plane(6, 1, 8'h77, "R6");
    setreg(1, 0);
    // R8 write mode 2
    setreg(4, 2); setreg(5, 8'hF0); memr(0, v); memw(7, 8'h06); setreg(4, 0); setreg(5, 8'hFF);
    chk_plane(7, 0, 8'h05, "R8");
    chk_plane(7, 1, 8'hF5, "R8");
    // R9 write mode 3
    setreg(4, 3); setreg(0, 8'h0A); memr(0, v); memw(8, 8'h0F); setreg(4, 0);
    chk_plane(8, 0, 8'hA0, "R9");
    chk_plane(8, 1, 8'hAF, "R9");
    // R11 colour compare read
    cur_req = "R11";
    setreg(4, 8); setreg(0, 2);
    memr(1, v); check("R11 compare one plane", {24'd0, v}, 8'h22);
    setreg(0, 15); memr(0, v); check("R11 compare all ones", {24'd0, v}, 8'hA5);
    setreg(0, 0);  memr(0, v); check("R11 compare all zeros", {24'd0, v}, 8'h5A);
    setreg(4, 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule